// File: doc/BRIEF.md
# Serial Glitch-Free Clock Stop Controller

This block gates a set of twelve clock outputs under the control of a small serial port. A free-running serial clock and a single data line load a 12-bit enable word. Each bit of that word decides whether one output clock runs or is held at logic low. Two further clocks, the bank-C lane 0 clock and the feedback clock, pass through with no gating, because stopping them would break the clock tree or the loop that feeds it.

A frame opens with a low start bit and carries twelve NRZ enable bits, one per serial clock period. The receiver assembles the whole word and then commits it in a single step. Each gate cell moves the new enable into its own clock domain through flops that update on that clock's falling edge. As a result, a gated output only starts or stops while its source clock is already low, and no high pulse is ever cut short or created partially.

Top module: `clk_stop_ctrl`

## Requirements
- R1: When no frame is in progress, the receiver stays idle while the data line is sampled high. A low level sampled on a rising serial clock edge in idle is taken as a start bit.
- R2: After the start bit, exactly twelve data bits are sampled, one on each following rising serial clock edge. The k-th bit after the start bit (k = 0..11) controls `clk_out[k]`. Index 0..3 is bank A lanes 0..3, 4..7 is bank B lanes 0..3, 8..10 is bank C lanes 1..3, and 11 is the sync pulse clock.
- R3: All twelve enables change together, on the rising edge that samples the twelfth data bit, and at no other time. After that edge the receiver is idle again, and another start bit may follow at once.
- R4: An enable of 0 holds its output at logic 0. An enable of 1 lets the output follow its source clock.
- R5: Every edge of a gated output coincides with an edge of its own source clock. An enable change takes effect only while the source clock is low, after `SYNC_STAGES` falling edges of that clock.
- R6: `clk_c0_out` and `clk_fb_out` always follow `clk_c0_in` and `clk_fb_in`, whatever the enable word.
- R7: A synchronous active-high reset sets all twelve enables to 1 in both the serial domain and the gate cells. It also discards any frame that is partly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial data line; idles high, start bit low |
| clk_in | input | 12 | Source clocks to be gated |
| clk_c0_in | input | 1 | Ungated bank-C lane 0 source clock |
| clk_fb_in | input | 1 | Ungated feedback source clock |
| clk_out | output | 12 | Gated clocks |
| clk_c0_out | output | 1 | Pass-through of clk_c0_in |
| clk_fb_out | output | 1 | Pass-through of clk_fb_in |

## Verification
The embedded assertions check the receiver on every serial clock cycle: start-bit detection, holding idle on a high line, the bit counter staying in range, the enable word staying constant except on the last-bit edge, and the last sampled bit landing in the top enable position. In every gate cell, an assertion checks that the delivered enable only changes while the source clock is low. The bench scenarios are the only place that shows end-to-end effects: the bit-to-output mapping, whole patterns stopping and starting real clocks, back-to-back frames, idle periods being ignored, a cut frame being discarded by reset, and the absence of runt pulses measured against source edge times.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/csc_frame_rx.sv
module csc_frame_rx
  import csc_pkg::*;
#(
  parameter int unsigned NUM_CLK = 12
) (
  input  logic               sclk,
  input  logic               rst,
  input  logic               sdata,
  output logic [NUM_CLK-1:0] en_o
);
  localparam int unsigned CW = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;
  localparam logic [CW-1:0] LAST = CW'(NUM_CLK - 1);

  rx_state_e          state;
  logic [CW-1:0]      cnt;
  logic [NUM_CLK-1:0] shreg;
  logic [NUM_CLK-1:0] shnext;
  logic [NUM_CLK-1:0] en_q;

  always_comb begin
    shnext      = shreg;
    shnext[cnt] = sdata;
  end

  always_ff @(posedge sclk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      shreg <= '1;
      en_q  <= '1;
    end else begin
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!sdata) state <= RX_SHIFT;
        end
        RX_SHIFT: begin
          if (cnt == LAST) begin
            en_q  <= shnext;
            shreg <= '1;
            cnt   <= '0;
            state <= RX_IDLE;
          end else begin
            shreg <= shnext;
            cnt   <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign en_o = en_q;

  // R1
  start_detect_chk: assert property (@(posedge sclk) disable iff (rst)
    (state == RX_IDLE && !sdata) |=> (state == RX_SHIFT && cnt == '0));
  // R1
  idle_hold_chk: assert property (@(posedge sclk) disable iff (rst)
    (state == RX_IDLE && sdata) |=> (state == RX_IDLE));
  // R3
  en_hold_chk: assert property (@(posedge sclk) disable iff (rst)
    !(state == RX_SHIFT && cnt == LAST) |=> $stable(en_q));
  // R3
  no_overflow_chk: assert property (@(posedge sclk) disable iff (rst)
    (state == RX_SHIFT) |-> (cnt <= LAST));
  // R2
  last_bit_chk: assert property (@(posedge sclk) disable iff (rst)
    (state == RX_SHIFT && cnt == LAST) |=> (en_q[NUM_CLK-1] == $past(sdata)));
  // R7
  reset_ones_chk: assert property (@(posedge sclk)
    $fell(rst) |-> (&en_q));
endmodule

// File: rtl/csc_gate_cell.sv
module csc_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst,
  input  logic en_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] chain;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(negedge clk_i) begin
        if (rst) chain <= '1;
        else     chain <= en_i;
      end
    end else begin : g_multi
      always_ff @(negedge clk_i) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_STAGES-2:0], en_i};
      end
    end
  endgenerate

  assign clk_o = clk_i & chain[SYNC_STAGES-1];

  // R5
  always @(chain[SYNC_STAGES-1]) begin
    if (rst == 1'b0) begin
      gate_low_chk: assert (clk_i == 1'b0);
    end
  end
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int unsigned NUM_CLK     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               sclk,
  input  logic               rst,
  input  logic               sdata,
  input  logic [NUM_CLK-1:0] clk_in,
  input  logic               clk_c0_in,
  input  logic               clk_fb_in,
  output logic [NUM_CLK-1:0] clk_out,
  output logic               clk_c0_out,
  output logic               clk_fb_out
);
  logic [NUM_CLK-1:0] en_word;

  csc_frame_rx #(.NUM_CLK(NUM_CLK)) u_rx (
    .sclk  (sclk),
    .rst   (rst),
    .sdata (sdata),
    .en_o  (en_word)
  );

  generate
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_gate
      csc_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i (clk_in[g]),
        .rst   (rst),
        .en_i  (en_word[g]),
        .clk_o (clk_out[g])
      );
    end
  endgenerate

  // R6: these two lanes are never gated
  assign clk_c0_out = clk_c0_in;
  assign clk_fb_out = clk_fb_in;
endmodule

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  localparam int NCLK = 12;

  logic            sclk = 1'b0;
  logic            rst  = 1'b1;
  logic            sdata = 1'b1;
  logic [NCLK-1:0] clk_in;
  logic            c0_in = 1'b0;
  logic            fb_in = 1'b0;
  logic [NCLK-1:0] clk_out;
  logic            c0_out, fb_out;

  int checks = 0;
  int failures = 0;
  int runt_err = 0;
  int rise_cnt [NCLK];
  int c0_rises = 0;
  int fb_rises = 0;
  logic [NCLK-1:0] prev_out = '0;
  logic [NCLK-1:0] exp_q [$];
  bit mon_busy = 0;
  bit run_done = 0;

  always #10 sclk = ~sclk;
  always #7  c0_in = ~c0_in;
  always #11 fb_in = ~fb_in;

  function automatic int half_of(int k);
    return 8 + 2 * k;
  endfunction

  generate
    for (genvar g = 0; g < NCLK; g++) begin : g_src
      logic ck = 1'b0;
      initial forever #(half_of(g)) ck = ~ck;
      assign clk_in[g] = ck;
    end
  endgenerate

  clk_stop_ctrl u_clk_stop_ctrl (
    .sclk(sclk), .rst(rst), .sdata(sdata),
    .clk_in(clk_in), .clk_c0_in(c0_in), .clk_fb_in(fb_in),
    .clk_out(clk_out), .clk_c0_out(c0_out), .clk_fb_out(fb_out)
  );

  initial for (int k = 0; k < NCLK; k++) rise_cnt[k] = 0;

  // edge bookkeeping and R5 runt detection
  always @(clk_out) begin
    for (int k = 0; k < NCLK; k++) begin
      if (clk_out[k] !== prev_out[k]) begin
        if (($time % half_of(k)) != 0) runt_err++;
        if (clk_out[k] === 1'b1) rise_cnt[k]++;
      end
    end
    prev_out = clk_out;
  end
  always @(posedge c0_out) c0_rises++;
  always @(posedge fb_out) fb_rises++;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: frame bit k goes to clk_out[k]
  task automatic send_bits(input logic [NCLK-1:0] bits, input bit idle_after);
    @(negedge sclk) sdata = 1'b0;
    for (int k = 0; k < NCLK; k++) begin
      @(negedge sclk) sdata = bits[k];
    end
    if (idle_after) @(negedge sclk) sdata = 1'b1;
  endtask

  task automatic expect_and_wait(input logic [NCLK-1:0] pat);
    exp_q.push_back(pat);
    wait (exp_q.size() == 0);
    wait (!mon_busy);
  endtask

  // monitor: pops expected word, measures outputs
  initial begin
    int snap [NCLK];
    int c0s, fbs;
    logic [NCLK-1:0] e;
    forever begin
      wait (exp_q.size() > 0);
      mon_busy = 1;
      e = exp_q.pop_front();
      #300;
      for (int k = 0; k < NCLK; k++) snap[k] = rise_cnt[k];
      c0s = c0_rises;
      fbs = fb_rises;
      #480;
      for (int k = 0; k < NCLK; k++) begin
        // R2 R4: each bit controls its own output
        check(((rise_cnt[k] - snap[k]) > 0) == e[k], $sformatf("R4/R2 out%0d", k),
              (rise_cnt[k] - snap[k]) > 0, e[k]);
      end
      // R6
      check((c0_rises - c0s) > 0 && (fb_rises - fbs) > 0, "R6 passthrough",
            (c0_rises - c0s) > 0 && (fb_rises - fbs) > 0, 1);
      mon_busy = 0;
    end
  end

  task automatic finish_run();
    // R5: no gated edge away from a source edge
    check(runt_err == 0, "R5 runt", runt_err, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!run_done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge sclk);
    rst = 1'b0;
    // R7: reset state, all outputs running
    expect_and_wait(12'hFFF);
    // R4: stop everything
    send_bits(12'h000, 1);
    expect_and_wait(12'h000);
    // R2: single bits mark order
    send_bits(12'h001, 1);
    expect_and_wait(12'h001);
    send_bits(12'h800, 1);
    expect_and_wait(12'h800);
    // R2 R4 mixed patterns
    send_bits(12'hA5C, 1);
    expect_and_wait(12'hA5C);
    send_bits(12'h3F0, 1);
    expect_and_wait(12'h3F0);
    // R1: long idle high leaves word unchanged
    repeat (40) @(negedge sclk) sdata = 1'b1;
    expect_and_wait(12'h3F0);
    // R3: back-to-back frames, start bit right after last bit
    send_bits(12'h0F0, 0);
    send_bits(12'hC03, 1);
    expect_and_wait(12'hC03);
    // R7: frame cut by reset is discarded
    @(negedge sclk) sdata = 1'b0;
    repeat (6) @(negedge sclk) sdata = 1'b0;
    rst = 1'b1;
    sdata = 1'b1;
    repeat (5) @(negedge sclk);
    rst = 1'b0;
    expect_and_wait(12'hFFF);
    // R3: a frame after reset still loads whole word
    send_bits(12'h555, 1);
    expect_and_wait(12'h555);
    run_done = 1;
    finish_run();
  end
endmodule